// File: doc/BRIEF.md
# USB OUT Endpoint Control

This block holds the control and status state of one high-speed USB device OUT endpoint. The protocol engine reports each received packet with its byte count and two error indications. The block decides whether that packet is answered with ACK or NYET, and whether it is kept or dropped. It then tracks the kept packets until the firmware or a DMA engine has unloaded them one byte per strobe.

A small CPU register port carries two registers. The status register at address 0 holds the packet-ready bit in bit 0. The control register at address 1 holds the endpoint configuration and the two isochronous error flags. The maximum packet size comes in on a port. Depending on the configuration, packet-ready clears by itself after a full-size unload, and a level DMA request is raised for each waiting packet.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After a synchronous reset, `pkt_rdy`, `dma_req`, `hs_valid` and `hs_nyet` are 0, and both registers read 0x00.
- R2: With control bit 5 (single buffer) at 0 the endpoint holds two packets, and with it at 1 it holds one. A packet that arrives while every slot is occupied is dropped and does not change the stored packets.
- R3: `hs_valid` is 1 in the cycle after `rx_valid`. `hs_nyet` is 1 in that cycle only if, at arrival, the endpoint was in bulk/interrupt mode (control bit 1 = 0), NYET was allowed (control bit 3 = 0) and all slots were full. Otherwise the answer is ACK.
- R4: Writing address 0 with bit 0 = 0 retires the current packet. Writing bit 0 = 1 has no effect.
- R5: With auto-clear (control bit 0) set, the current packet is retired when its last byte is unloaded, but only if its length equals `maxp`. A shorter packet stays ready.
- R6: `pkt_rdy` is 1 while any packet is held. After a packet is retired, the next held packet is current from the following cycle.
- R7: `dma_req` requires control bit 2 (DMA enable). In request mode 0 (control bit 4 = 0, written in bulk mode) it asserts for every held packet. In mode 1 it asserts only for a packet of length `maxp`.
- R8: `dma_req` is a level that stays 1 until every byte of the current packet has been unloaded.
- R9: Control bit 4 reads as the PID-error flag in isochronous mode (control bit 1 = 1) and as the DMA mode in bulk mode. The flag is set only by a packet with `rx_pid_err` in isochronous mode. In isochronous mode, writing 0 to bit 4 clears it and writing 1 leaves it unchanged.
- R10: Control bit 6 (read-only) shows the incomplete flag of the current packet. The flag is stored only for packets received in isochronous mode, vanishes when that packet is retired, and reads 0 in bulk mode.
- R11: Unload strobes while no packet is held, or beyond the current packet's length, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle pulse: a packet was received |
| rx_len | input | CNT_W | Byte count of the received packet |
| rx_pid_err | input | 1 | Received packet carried a PID error |
| rx_incomplete | input | 1 | Received packet was incomplete |
| maxp | input | CNT_W | Configured maximum packet size |
| rd_strobe | input | 1 | Unload one byte of the current packet |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 1 | 0 = status, 1 = control |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data |
| hs_valid | output | 1 | Handshake decision valid |
| hs_nyet | output | 1 | 1 = NYET, 0 = ACK |
| dma_req | output | 1 | DMA request level |
| pkt_rdy | output | 1 | A packet is waiting |

## Verification
The bench builds the block with the default two slots and an 11-bit count. It drives `maxp` at 8, so a full-size packet is unloaded in eight strobes, and both the full-size and short-packet paths of auto-clear and DMA mode 1 are reached quickly. Two slots make it possible to reach the state with a second packet queued behind the current one, and to reach the full state in both buffering settings, so that the handshake choice and packet dropping can be observed.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int B_AUTO   = 0;
  localparam int B_ISO    = 1;
  localparam int B_DMAEN  = 2;
  localparam int B_NYOFF  = 3;
  localparam int B_DUAL   = 4;
  localparam int B_SBUF   = 5;
  localparam int B_INCOMP = 6;

  typedef struct packed {
    logic single_buf;
    logic dma_mode;
    logic nyet_off;
    logic dma_en;
    logic iso;
    logic auto_clr;
  } ep_cfg_t;
endpackage

// File: rtl/ep_slot_queue.sv
// Packet slot tracker. SLOTS must be a power of two, at least 2.
module ep_slot_queue #(
  parameter int SLOTS = 2,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [CNT_W-1:0] push_len,
  input  logic             push_inc,
  input  logic             single_buf,
  input  logic             sw_pop,
  input  logic             auto_clr,
  input  logic [CNT_W-1:0] maxp,
  input  logic             rd_strobe,
  output logic             nonempty,
  output logic             full,
  output logic [CNT_W-1:0] head_len,
  output logic             head_inc,
  output logic [CNT_W-1:0] unl
);
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CW    = $clog2(SLOTS + 1);

  logic [CNT_W-1:0] len_mem [SLOTS];
  logic             inc_mem [SLOTS];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             do_push, rd_ok, last_byte, auto_pop, do_pop;
  logic [CNT_W-1:0] unl_inc;

  assign nonempty  = (cnt != '0);
  assign full      = single_buf ? nonempty : (cnt == CW'(SLOTS));
  assign head_len  = len_mem[rd_ptr];
  assign head_inc  = inc_mem[rd_ptr];
  assign do_push   = push & ~full;
  assign rd_ok     = rd_strobe & nonempty & (unl < head_len);
  assign unl_inc   = unl + 1'b1;
  assign last_byte = rd_ok & (unl_inc == head_len);
  assign auto_pop  = last_byte & auto_clr & (head_len == maxp);
  assign do_pop    = nonempty & (sw_pop | auto_pop);

  // Slot storage without reset, so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (do_push) begin
      len_mem[wr_ptr] <= push_len;
      inc_mem[wr_ptr] <= push_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      unl    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (do_pop)      unl <= '0;
      else if (rd_ok)  unl <= unl_inc;
    end
  end

  // R2: a packet arriving while full never adds to the occupancy
  a_r2_no_grow_when_full: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (cnt <= $past(cnt)));
  // R8: unloaded count never passes the current packet length
  a_r8_unl_in_bound: assert property (@(posedge clk) disable iff (rst)
    nonempty |-> (unl <= head_len));
  // R11: with nothing held, no unload progress is recorded
  a_r11_idle_unl_zero: assert property (@(posedge clk) disable iff (rst)
    !nonempty |-> (unl == '0));
endmodule

// File: rtl/ep_ctrl_regs.sv
module ep_ctrl_regs
  import usb_out_ep_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_en,
  input  logic    addr,
  input  logic [7:0] wdata,
  input  logic    rx_valid,
  input  logic    rx_pid_err,
  input  logic    pkt_rdy,
  input  logic    head_inc,
  output ep_cfg_t cfg,
  output logic    sw_pop,
  output logic [7:0] rdata
);
  logic pid_err;
  logic wr_ctrl;
  logic unused_wbits;

  assign wr_ctrl      = wr_en & (addr == ADDR_CTRL);
  assign sw_pop       = wr_en & (addr == ADDR_STAT) & ~wdata[0];
  assign unused_wbits = ^wdata[7:6];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      pid_err <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cfg.auto_clr   <= wdata[B_AUTO];
        cfg.iso        <= wdata[B_ISO];
        cfg.dma_en     <= wdata[B_DMAEN];
        cfg.nyet_off   <= wdata[B_NYOFF];
        cfg.single_buf <= wdata[B_SBUF];
        if (!cfg.iso) cfg.dma_mode <= wdata[B_DUAL];
      end
      if (rx_valid && rx_pid_err && cfg.iso)          pid_err <= 1'b1;
      else if (wr_ctrl && cfg.iso && !wdata[B_DUAL])  pid_err <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_STAT) begin
      rdata[0] = pkt_rdy;
    end else begin
      rdata[B_AUTO]   = cfg.auto_clr;
      rdata[B_ISO]    = cfg.iso;
      rdata[B_DMAEN]  = cfg.dma_en;
      rdata[B_NYOFF]  = cfg.nyet_off;
      rdata[B_DUAL]   = cfg.iso ? pid_err : cfg.dma_mode;
      rdata[B_SBUF]   = cfg.single_buf;
      rdata[B_INCOMP] = cfg.iso & pkt_rdy & head_inc;
    end
  end

  // R9: the PID-error flag only rises after a cycle spent in isochronous mode
  a_r9_pid_iso_only: assert property (@(posedge clk) disable iff (rst)
    $rose(pid_err) |-> $past(cfg.iso));
endmodule

// File: rtl/ep_dma_req.sv
module ep_dma_req #(
  parameter int CNT_W = 11
) (
  input  logic             enable,
  input  logic             full_only,
  input  logic             nonempty,
  input  logic [CNT_W-1:0] head_len,
  input  logic [CNT_W-1:0] unl,
  input  logic [CNT_W-1:0] maxp,
  output logic             req
);
  logic qualifies;
  assign qualifies = ~full_only | (head_len == maxp);
  assign req = enable & nonempty & (unl < head_len) & qualifies;
endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl
  import usb_out_ep_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [CNT_W-1:0] rx_len,
  input  logic             rx_pid_err,
  input  logic             rx_incomplete,
  input  logic [CNT_W-1:0] maxp,
  input  logic             rd_strobe,
  input  logic             cpu_wr,
  input  logic             cpu_addr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  output logic             hs_valid,
  output logic             hs_nyet,
  output logic             dma_req,
  output logic             pkt_rdy
);
  ep_cfg_t          cfg;
  logic             sw_pop, nonempty, full, head_inc;
  logic [CNT_W-1:0] head_len, unl;

  assign pkt_rdy = nonempty;

  ep_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .addr(cpu_addr), .wdata(cpu_wdata),
    .rx_valid(rx_valid), .rx_pid_err(rx_pid_err), .pkt_rdy(nonempty),
    .head_inc(head_inc), .cfg(cfg), .sw_pop(sw_pop), .rdata(cpu_rdata)
  );

  ep_slot_queue #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_q (
    .clk(clk), .rst(rst), .push(rx_valid), .push_len(rx_len),
    .push_inc(rx_incomplete & cfg.iso), .single_buf(cfg.single_buf),
    .sw_pop(sw_pop), .auto_clr(cfg.auto_clr), .maxp(maxp), .rd_strobe(rd_strobe),
    .nonempty(nonempty), .full(full), .head_len(head_len), .head_inc(head_inc),
    .unl(unl)
  );

  ep_dma_req #(.CNT_W(CNT_W)) u_dma (
    .enable(cfg.dma_en), .full_only(cfg.dma_mode), .nonempty(nonempty),
    .head_len(head_len), .unl(unl), .maxp(maxp), .req(dma_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_nyet  <= 1'b0;
    end else begin
      hs_valid <= rx_valid;
      hs_nyet  <= rx_valid & ~cfg.iso & ~cfg.nyet_off & full;
    end
  end

  // R3: every received packet gets a handshake decision one cycle later
  a_r3_hs_follows_rx: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> hs_valid);
  // R3: NYET is only ever a qualified handshake
  a_r3_nyet_has_valid: assert property (@(posedge clk) disable iff (rst)
    hs_nyet |-> hs_valid);
  // R7: a DMA request always refers to a waiting packet
  a_r7_dma_needs_pkt: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> pkt_rdy);
endmodule

// File: tb/sim_usb_out_ep_ctrl.sv
`timescale 1ns/1ps
module sim_usb_out_ep_ctrl;
  localparam int CNT_W = 11;
  localparam int MAXP  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_pid_err = 0, rx_incomplete = 0, rd_strobe = 0;
  logic [CNT_W-1:0] rx_len = '0;
  logic [CNT_W-1:0] maxp = CNT_W'(MAXP);
  logic cpu_wr = 0, cpu_addr = 0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic hs_valid, hs_nyet, dma_req, pkt_rdy;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  usb_out_ep_ctrl #(.SLOTS(2), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_len(rx_len),
    .rx_pid_err(rx_pid_err), .rx_incomplete(rx_incomplete), .maxp(maxp),
    .rd_strobe(rd_strobe), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .hs_valid(hs_valid),
    .hs_nyet(hs_nyet), .dma_req(dma_req), .pkt_rdy(pkt_rdy)
  );

  // ---------------- behavioural reference model ----------------
  int ql[$];
  bit qi[$];
  int unl;
  bit m_auto, m_iso, m_dmaen, m_nyoff, m_mode, m_sbuf, m_pid, m_hsv, m_hsn;

  always @(posedge clk) begin
    bit ne, full, rdok, aut, pop, cw, iso_old;
    int hl;
    if (rst) begin
      ql.delete(); qi.delete(); unl = 0;
      {m_auto, m_iso, m_dmaen, m_nyoff, m_mode, m_sbuf, m_pid, m_hsv, m_hsn} = '0;
    end else begin
      ne   = ql.size() > 0;
      hl   = ne ? ql[0] : 0;
      full = m_sbuf ? (ql.size() >= 1) : (ql.size() >= 2);
      rdok = rd_strobe && ne && (unl < hl);
      aut  = rdok && (unl + 1 == hl) && m_auto && (hl == int'(maxp));
      pop  = ne && ((cpu_wr && cpu_addr == 1'b0 && !cpu_wdata[0]) || aut);
      cw   = cpu_wr && cpu_addr == 1'b1;
      iso_old = m_iso;
      m_hsv = rx_valid;
      m_hsn = rx_valid && !m_iso && !m_nyoff && full;
      if (rx_valid && rx_pid_err && m_iso) m_pid = 1;
      else if (cw && m_iso && !cpu_wdata[4]) m_pid = 0;
      if (cw) begin
        m_auto = cpu_wdata[0]; m_iso = cpu_wdata[1]; m_dmaen = cpu_wdata[2];
        m_nyoff = cpu_wdata[3]; m_sbuf = cpu_wdata[5];
        if (!iso_old) m_mode = cpu_wdata[4];
      end
      if (pop) begin void'(ql.pop_front()); void'(qi.pop_front()); unl = 0; end
      else if (rdok) unl++;
      if (rx_valid && !full) begin
        ql.push_back(int'(rx_len));
        qi.push_back(rx_incomplete && iso_old);
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 5 ns after the edge
  always @(posedge clk) begin
    bit ne;
    int e_dma, e_rd;
    #5;
    if (!rst) begin
      ne = ql.size() > 0;
      e_dma = (m_dmaen && ne && unl < ql[0] && (!m_mode || ql[0] == MAXP)) ? 1 : 0;
      if (cpu_addr == 1'b0) e_rd = ne ? 1 : 0;
      else e_rd = {1'b0, (m_iso && ne && qi[0]), m_sbuf, (m_iso ? m_pid : m_mode),
                   m_nyoff, m_dmaen, m_iso, m_auto};
      cmp("R6 pkt_rdy", int'(pkt_rdy), ne ? 1 : 0);
      cmp("R3 hs_valid", int'(hs_valid), int'(m_hsv));
      cmp("R3 hs_nyet", int'(hs_nyet), int'(m_hsn));
      cmp("R8 dma_req", int'(dma_req), e_dma);
      cmp("R9 cpu_rdata", int'(cpu_rdata), e_rd);
    end
  end

  // ---------------- stimulus tasks (enter and leave at a negedge) ----------------
  task automatic pkt(int len, bit pe = 0, bit inc = 0);
    rx_valid = 1; rx_len = CNT_W'(len); rx_pid_err = pe; rx_incomplete = inc;
    @(negedge clk);
    rx_valid = 0; rx_pid_err = 0; rx_incomplete = 0;
  endtask

  task automatic wr(bit a, logic [7:0] d);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 0; cpu_addr = 0;
  endtask

  task automatic unload(int n);
    for (int i = 0; i < n; i++) begin
      rd_strobe = 1;
      @(negedge clk);
    end
    rd_strobe = 0;
  endtask

  task automatic readreg(bit a, output int v);
    cpu_addr = a; #1; v = int'(cpu_rdata);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    cmp("R1 pkt_rdy", int'(pkt_rdy), 0);
    cmp("R1 dma_req", int'(dma_req), 0);
    readreg(1, v); cmp("R1 ctrl", v, 0);
    readreg(0, v); cmp("R1 stat", v, 0);

    // R2/R3: double buffering, NYET allowed
    pkt(4); cmp("R3 first ack", int'(hs_nyet), 0);
    pkt(6); cmp("R3 second ack", int'(hs_nyet), 0);
    pkt(5); cmp("R3 nyet when full", int'(hs_nyet), 1);
    wr(0, 8'h01); cmp("R4 write one ignored", int'(pkt_rdy), 1);
    wr(0, 8'h00); cmp("R6 next current", int'(pkt_rdy), 1);
    wr(0, 8'h00); cmp("R2 dropped third", int'(pkt_rdy), 0);

    // R3: NYET disabled
    wr(1, 8'h08);
    pkt(2); pkt(2); pkt(2); cmp("R3 ack when nyet off", int'(hs_nyet), 0);
    wr(0, 8'h00); wr(0, 8'h00); cmp("R2 two held", int'(pkt_rdy), 0);

    // R2: single buffer
    wr(1, 8'h20);
    pkt(3); pkt(3); cmp("R2 single full nyet", int'(hs_nyet), 1);
    wr(0, 8'h00); cmp("R2 single held one", int'(pkt_rdy), 0);

    // R5: auto-clear
    wr(1, 8'h01);
    pkt(MAXP); unload(MAXP - 1); cmp("R5 not yet", int'(pkt_rdy), 1);
    unload(1); cmp("R5 full size clears", int'(pkt_rdy), 0);
    pkt(5); unload(5); cmp("R5 short stays", int'(pkt_rdy), 1);
    unload(2); wr(0, 8'h00);
    pkt(MAXP); pkt(3); unload(MAXP); cmp("R6 second after auto", int'(pkt_rdy), 1);
    wr(0, 8'h00);

    // R7/R8: DMA mode 0 then mode 1
    wr(1, 8'h04);
    pkt(3); cmp("R7 mode0 req", int'(dma_req), 1);
    unload(2); cmp("R8 held", int'(dma_req), 1);
    unload(1); cmp("R8 drops after unload", int'(dma_req), 0);
    wr(0, 8'h00);
    wr(1, 8'h14);
    pkt(3); cmp("R7 mode1 short no req", int'(dma_req), 0);
    wr(0, 8'h00);
    pkt(MAXP); cmp("R7 mode1 full req", int'(dma_req), 1);
    unload(MAXP); wr(0, 8'h00);
    wr(1, 8'h10);
    pkt(MAXP); cmp("R7 disabled", int'(dma_req), 0);
    wr(0, 8'h00);

    // R9/R10: isochronous flags
    wr(1, 8'h02);
    pkt(4, 1, 1);
    readreg(1, v); cmp("R9 R10 iso flags", v, 8'h52);
    wr(1, 8'h12); readreg(1, v); cmp("R9 write one keeps", v, 8'h52);
    wr(1, 8'h02); readreg(1, v); cmp("R9 write zero clears", v, 8'h42);
    wr(0, 8'h00); readreg(1, v); cmp("R10 cleared with pkt", v, 8'h02);
    wr(1, 8'h00);
    pkt(2, 1, 1); readreg(1, v); cmp("R9 R10 bulk ignores", v, 8'h00);
    wr(0, 8'h00);
    wr(1, 8'h02); readreg(1, v); cmp("R9 not latched in bulk", v, 8'h02);

    // R11: strobes while empty
    wr(1, 8'h04);
    unload(3);
    pkt(2); cmp("R11 idle strobes ignored", int'(dma_req), 1);
    unload(1); cmp("R11 one left", int'(dma_req), 1);
    unload(3); cmp("R11 extra strobes", int'(pkt_rdy), 1);
    wr(0, 8'h00);
    repeat (3) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule